// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block calibrates a UART's baud-rate divisor from the line itself. Software writes a start pulse. The block then waits for a 55h sync character on the receive pin and measures it. Sent LSB first with start and stop bits, 55h gives five rising edges. The first edge ends the start bit and the last edge starts the stop bit, so the first and fifth edges are exactly eight bit times apart.

The count is kept in a 16-bit accumulator. It advances once every N system clocks, where N is eight times the divisor base rate picked by the two mode bits. After eight bit periods the accumulator therefore holds the average bit divisor directly. When the fifth edge arrives, the result goes into the divisor register, the busy (enable) indication drops and the receive interrupt flag rises. While busy is high, the normal receiver must stay in idle.

In an optional armed mode, measurement starts only after an external break detector reports a break. A trim option removes the +1 that comes from the counter starting at one.

Top module: `autobaud_detector`

## Requirements
- R1: A one-cycle `cfg_start` with `cfg_async`=1 while idle makes `busy` go high on the next clock and latches `cfg_wide`, `cfg_fast`, `cfg_trim` and `cfg_wake` for the whole run. A start with `cfg_async`=0, or while `busy` is high, has no effect.
- R2: `rx_in` passes through a two-flop synchronizer, and only its rising edges are counted. A rising edge applied before a clock edge E completes the run at the third clock edge counting from E. Lows and falling edges never complete a run.
- R3: Let L be the number of clocks from the first counted rising edge to the fifth. The raw result is 1 + floor(L / N), where N is the tick period in clocks.
- R4: The mode `{cfg_wide,cfg_fast}` sets N to 512 for 00, to 128 for 01 and 10, and to 32 for 11.
- R5: With trim latched at 1, the stored divisor is the raw result minus one. With trim at 0 it is the raw result.
- R6: If the raw result exceeds the largest divisor value (all ones), the divisor saturates at all ones with no trim applied, and `ovf_flag` is set. `ovf_flag` is cleared by the next accepted start.
- R7: `irq_flag` is set at the same clock edge at which `busy` falls. It is cleared by `rd_strobe`, and a completion in the same cycle as `rd_strobe` wins.
- R8: With wake latched, rising edges are ignored until `break_seen` is sampled high. The byte after the break is then measured.
- R9: `busy` stays high from the accepted start until completion. This tells the receive state machine to stay idle.
- R10: `divisor` resets to 0 and changes only at the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the oscillator rate the ratios divide) |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous receive line, idle high |
| cfg_start | input | 1 | Start pulse for one detection run |
| cfg_async | input | 1 | High when the UART is set up for asynchronous mode |
| cfg_wake | input | 1 | Arm on break: measure the byte after a break |
| cfg_wide | input | 1 | 16-bit divisor mode bit (selects ratio) |
| cfg_fast | input | 1 | High-speed mode bit (selects ratio) |
| cfg_trim | input | 1 | Subtract one from the result on completion |
| break_seen | input | 1 | One-cycle pulse from the external break detector |
| rd_strobe | input | 1 | Read of the receive data register, clears the flag |
| busy | output | 1 | Detection in progress; holds the receiver in idle |
| divisor | output | DIV_W (16) | Measured baud-rate divisor |
| irq_flag | output | 1 | Receive interrupt flag raised on completion |
| ovf_flag | output | 1 | Result saturated during the last run |

## Verification
A stuck or mis-stepped edge counter shows at the ports in one of two ways. Either `busy` falls too early, at the second or fourth rising edge, or it never falls. Both are seen within two clocks of the relevant edge because the reference model tracks completion cycle by cycle. A wrong prescaler ratio or tick phase gives a `divisor` that is off by a whole mode factor or by one, and it is visible on the clock after completion. A stale overflow accumulator, or mode bits that are not latched, show on the next run's `ovf_flag` or `divisor`. Runs started in mid-measurement and runs that straddle a break cover these paths.

// File: rtl/abd_pkg.sv
package abd_pkg;

   // Run phase of the detector.
   typedef enum logic [1:0] {
      PH_IDLE  = 2'b00,
      PH_BREAK = 2'b01,
      PH_ARMED = 2'b10,
      PH_COUNT = 2'b11
   } abd_phase_e;

   // Ratio select, encoded as {wide, fast}.
   typedef enum logic [1:0] {
      RT_SLOW  = 2'b00,
      RT_MID_A = 2'b01,
      RT_MID_B = 2'b10,
      RT_FAST  = 2'b11
   } abd_ratio_e;

   // Number of rising edges that close a measurement.
   localparam int unsigned EDGES_PER_SYNC = 5;

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_async,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;
   logic              clean;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("abd_sync: STAGES must be at least 2");
      end
   endgenerate

   // Line idles high, so reset every stage to 1 to avoid a false edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '1;
         last_q <= 1'b1;
      end else begin
         chain  <= {chain[STAGES-2:0], rx_async};
         last_q <= clean;
      end
   end

   assign clean = chain[STAGES-1];
   assign rise  = clean & ~last_q;
endmodule

// File: rtl/abd_prescaler.sv
module abd_prescaler
   import abd_pkg::*;
#(
   parameter int unsigned BASE_SLOW = 64,
   parameter int unsigned BASE_MID  = 16,
   parameter int unsigned BASE_FAST = 4,
   parameter int unsigned OVS       = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       run,
   input  abd_ratio_e ratio,
   output logic       tick
);
   localparam int unsigned R_SLOW = BASE_SLOW * OVS;
   localparam int unsigned R_MID  = BASE_MID * OVS;
   localparam int unsigned R_FAST = BASE_FAST * OVS;
   localparam int unsigned PW     = $clog2(R_SLOW + 1);
   localparam logic [PW-1:0] LAST_SLOW = PW'(R_SLOW - 1);
   localparam logic [PW-1:0] LAST_MID  = PW'(R_MID - 1);
   localparam logic [PW-1:0] LAST_FAST = PW'(R_FAST - 1);

   generate
      if (BASE_FAST < 1 || BASE_MID < BASE_FAST || BASE_SLOW < BASE_MID) begin : g_bad_bases
         $error("abd_prescaler: bases must satisfy SLOW >= MID >= FAST >= 1");
      end
      if (OVS < 1) begin : g_bad_ovs
         $error("abd_prescaler: OVS must be at least 1");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] last_val;

   always_comb begin
      unique case (ratio)
         RT_SLOW:  last_val = LAST_SLOW;
         RT_MID_A: last_val = LAST_MID;
         RT_MID_B: last_val = LAST_MID;
         default:  last_val = LAST_FAST;
      endcase
   end

   assign tick = run && (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= tick ? '0 : cnt_q + PW'(1);
      end
   end
endmodule

// File: rtl/abd_meas.sv
module abd_meas
   import abd_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             async_ok,
   input  logic             wake,
   input  logic             trim,
   input  abd_ratio_e       ratio_in,
   input  logic             break_seen,
   input  logic             rise,
   input  logic             tick,
   input  logic             rd_strobe,
   output abd_ratio_e       ratio_q,
   output logic             pre_clear,
   output logic             pre_run,
   output logic             busy,
   output logic [DIV_W-1:0] divisor,
   output logic             irq_flag,
   output logic             ovf_flag
);
   localparam logic [DIV_W-1:0] ACC_MAX   = '1;
   localparam logic [DIV_W-1:0] ACC_ONE   = DIV_W'(1);
   localparam logic [2:0]       LAST_PRE  = 3'(EDGES_PER_SYNC - 1);

   abd_phase_e       phase_q;
   logic [2:0]       edge_idx_q;
   logic [DIV_W-1:0] acc_q;
   logic [DIV_W-1:0] acc_nxt;
   logic             sat_hit;
   logic             ovf_run_q;
   logic             trim_q;
   logic             done;
   logic             accept;
   logic             ovf_final;
   logic [DIV_W-1:0] result;

   assign accept    = (phase_q == PH_IDLE) && start && async_ok;
   assign sat_hit   = tick && (acc_q == ACC_MAX);
   assign acc_nxt   = (tick && !sat_hit) ? acc_q + ACC_ONE : acc_q;
   assign done      = (phase_q == PH_COUNT) && rise && (edge_idx_q == LAST_PRE);
   assign ovf_final = ovf_run_q | sat_hit;
   assign result    = (trim_q && !ovf_final) ? acc_nxt - ACC_ONE : acc_nxt;

   assign pre_clear = (phase_q == PH_ARMED) && rise;
   assign pre_run   = (phase_q == PH_COUNT);
   assign busy      = (phase_q != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         edge_idx_q <= '0;
         acc_q      <= '0;
         ovf_run_q  <= 1'b0;
         trim_q     <= 1'b0;
         ratio_q    <= RT_SLOW;
         divisor    <= '0;
         ovf_flag   <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  phase_q    <= wake ? PH_BREAK : PH_ARMED;
                  ratio_q    <= ratio_in;
                  trim_q     <= trim;
                  edge_idx_q <= '0;
                  ovf_run_q  <= 1'b0;
                  ovf_flag   <= 1'b0;
               end
            end
            PH_BREAK: begin
               if (break_seen) phase_q <= PH_ARMED;
            end
            PH_ARMED: begin
               if (rise) begin
                  phase_q    <= PH_COUNT;
                  edge_idx_q <= 3'd1;
                  acc_q      <= ACC_ONE;
                  ovf_run_q  <= 1'b0;
               end
            end
            default: begin
               acc_q     <= acc_nxt;
               ovf_run_q <= ovf_final;
               if (rise) edge_idx_q <= edge_idx_q + 3'd1;
               if (done) begin
                  phase_q  <= PH_IDLE;
                  divisor  <= result;
                  ovf_flag <= ovf_final;
               end
            end
         endcase
      end
   end

   // Completion takes precedence over a clearing read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_flag <= 1'b0;
      else if (done)      irq_flag <= 1'b1;
      else if (rd_strobe) irq_flag <= 1'b0;
   end
endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector
   import abd_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BASE_SLOW   = 64,
   parameter int unsigned BASE_MID    = 16,
   parameter int unsigned BASE_FAST   = 4,
   parameter int unsigned OVS         = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_in,
   input  logic             cfg_start,
   input  logic             cfg_async,
   input  logic             cfg_wake,
   input  logic             cfg_wide,
   input  logic             cfg_fast,
   input  logic             cfg_trim,
   input  logic             break_seen,
   input  logic             rd_strobe,
   output logic             busy,
   output logic [DIV_W-1:0] divisor,
   output logic             irq_flag,
   output logic             ovf_flag
);
   generate
      if (DIV_W < 4 || DIV_W > 32) begin : g_bad_width
         $error("autobaud_detector: DIV_W must lie in 4..32");
      end
   endgenerate

   logic       rise;
   logic       tick;
   logic       pre_clear;
   logic       pre_run;
   abd_ratio_e ratio_sel;
   abd_ratio_e ratio_q;

   assign ratio_sel = abd_ratio_e'({cfg_wide, cfg_fast});

   abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_async (rx_in),
      .rise     (rise)
   );

   abd_prescaler #(
      .BASE_SLOW (BASE_SLOW),
      .BASE_MID  (BASE_MID),
      .BASE_FAST (BASE_FAST),
      .OVS       (OVS)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (pre_clear),
      .run   (pre_run),
      .ratio (ratio_q),
      .tick  (tick)
   );

   abd_meas #(.DIV_W(DIV_W)) u_meas (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (cfg_start),
      .async_ok   (cfg_async),
      .wake       (cfg_wake),
      .trim       (cfg_trim),
      .ratio_in   (ratio_sel),
      .break_seen (break_seen),
      .rise       (rise),
      .tick       (tick),
      .rd_strobe  (rd_strobe),
      .ratio_q    (ratio_q),
      .pre_clear  (pre_clear),
      .pre_run    (pre_run),
      .busy       (busy),
      .divisor    (divisor),
      .irq_flag   (irq_flag),
      .ovf_flag   (ovf_flag)
   );
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_start,
   input logic             cfg_async,
   input logic             rd_strobe,
   input logic             busy,
   input logic [DIV_W-1:0] divisor,
   input logic             irq_flag,
   input logic             ovf_flag
);
   // R1: a start without asynchronous mode leaves the block idle
   p_no_sync_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_start && !cfg_async) |=> !busy);

   // R1: busy only rises after an accepted start
   p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cfg_start && cfg_async));

   // R7: completion raises the interrupt flag
   p_flag_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq_flag);

   // R7: the flag only drops after a read
   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag) |-> $past(rd_strobe));

   // R10: divisor holds while a run continues
   p_div_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(divisor));

   // R6: overflow status appears only at completion
   p_ovf_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $fell(busy));
endmodule

bind autobaud_detector abd_checker #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_start (cfg_start),
   .cfg_async (cfg_async),
   .rd_strobe (rd_strobe),
   .busy      (busy),
   .divisor   (divisor),
   .irq_flag  (irq_flag),
   .ovf_flag  (ovf_flag)
);

// File: tb/sim_autobaud_detector.sv
module sim_autobaud_detector;
   localparam int DW   = 10;
   localparam int MAXV = (1 << DW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_in = 1'b1;
   logic cfg_start = 1'b0, cfg_async = 1'b1, cfg_wake = 1'b0;
   logic cfg_wide = 1'b0, cfg_fast = 1'b0, cfg_trim = 1'b0;
   logic break_seen = 1'b0, rd_strobe = 1'b0;
   logic busy, irq_flag, ovf_flag;
   logic [DW-1:0] divisor;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   autobaud_detector #(.DIV_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_start(cfg_start),
      .cfg_async(cfg_async), .cfg_wake(cfg_wake), .cfg_wide(cfg_wide),
      .cfg_fast(cfg_fast), .cfg_trim(cfg_trim), .break_seen(break_seen),
      .rd_strobe(rd_strobe), .busy(busy), .divisor(divisor),
      .irq_flag(irq_flag), .ovf_flag(ovf_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int ratio_of(input int m);
      case (m)
         0: return 512;
         1, 2: return 128;
         default: return 32;
      endcase
   endfunction

   // Behavioural reference model of the requirements
   int m_ph, m_edges, m_len, m_mode, m_div, m_trim;
   bit m_s1, m_s2, m_prev, m_flag, m_ovf, m_wake;

   always @(posedge clk) begin
      bit rise, done;
      int v;
      if (!rst_n) begin
         m_ph = 0; m_edges = 0; m_len = 0; m_mode = 0; m_div = 0; m_trim = 0;
         m_s1 = 1; m_s2 = 1; m_prev = 1; m_flag = 0; m_ovf = 0; m_wake = 0;
      end else begin
         rise = m_s2 && !m_prev;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_in;
         done = 0;
         case (m_ph)
            0: if (cfg_start && cfg_async) begin
                  m_ph = cfg_wake ? 1 : 2;
                  m_mode = {cfg_wide, cfg_fast};
                  m_trim = cfg_trim;
                  m_ovf = 0;
               end
            1: if (break_seen) m_ph = 2;
            2: if (rise) begin m_ph = 3; m_edges = 1; m_len = 0; end
            default: begin
               m_len++;
               if (rise) begin
                  m_edges++;
                  if (m_edges == 5) begin
                     v = 1 + m_len / ratio_of(m_mode);
                     m_ovf = (v > MAXV);
                     if (m_ovf) v = MAXV;
                     else if (m_trim != 0) v = v - 1;
                     m_div = v;
                     m_ph = 0;
                     done = 1;
                  end
               end
            end
         endcase
         if (done) m_flag = 1;
         else if (rd_strobe) m_flag = 0;
      end
   end

   // Per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R9 busy", busy, (m_ph != 0));
         chk("R7 irq_flag", irq_flag, m_flag);
         chk("R3 divisor", divisor, m_div);
         chk("R6 ovf_flag", ovf_flag, m_ovf);
      end
   end

   task automatic kick(input bit wide, input bit fast, input bit trim, input bit wake, input bit asy);
      cfg_wide = wide; cfg_fast = fast; cfg_trim = trim; cfg_wake = wake; cfg_async = asy;
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      cfg_async = 1'b1;
   endtask

   task automatic send55(input int bitc, input int nbits);
      bit pat[10] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
      for (int i = 0; i < nbits; i++) begin
         rx_in = pat[i];
         repeat (bitc) @(negedge clk);
      end
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 60000 && busy; n++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset values
      chk("R10 reset divisor", divisor, 0);
      chk("R9 reset busy", busy, 0);
      chk("R7 reset flag", irq_flag, 0);

      // A: mode 11, bit 20, no trim -> 1+160/32 = 6; restart mid-run ignored (R1)
      kick(1, 1, 0, 0, 1);
      fork
         send55(20, 10);
         begin repeat (40) @(negedge clk); kick(0, 0, 1, 0, 1); end
      join
      wait_idle();
      chk("R4 mode11 divisor", divisor, 6);
      chk("R1 restart ignored", divisor, 6);

      // B: mode 01, bit 112, trim -> 1+896/128-1 = 7
      kick(0, 1, 1, 0, 1);
      send55(112, 10);
      wait_idle();
      chk("R5 trim mode01", divisor, 7);

      // C: mode 00, bit 192, trim -> 3
      kick(0, 0, 1, 0, 1);
      send55(192, 10);
      wait_idle();
      chk("R4 mode00 divisor", divisor, 3);

      // D: mode 10, bit 64 -> 1+512/128 = 5
      kick(1, 0, 0, 0, 1);
      send55(64, 10);
      wait_idle();
      chk("R4 mode10 divisor", divisor, 5);

      // E: uneven bit time 21 clocks, mode 11, trim -> 1+168/32-1 = 5
      kick(1, 1, 1, 0, 1);
      send55(21, 10);
      wait_idle();
      chk("R3 uneven bit", divisor, 5);

      // H: read clears flag
      chk("R7 flag after run", irq_flag, 1);
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
      chk("R7 flag cleared", irq_flag, 0);

      // F: start without async mode ignored
      kick(0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk("R1 no async start", busy, 0);

      // G: break-armed mode
      kick(1, 1, 0, 1, 1);
      send55(20, 10);
      repeat (5) @(negedge clk);
      chk("R8 ignored before break busy", busy, 1);
      chk("R8 ignored before break divisor", divisor, 5);
      break_seen = 1'b1; @(negedge clk); break_seen = 1'b0;
      send55(24, 10);
      wait_idle();
      chk("R8 after break divisor", divisor, 7);

      // J: completion timing on the fifth rising edge
      kick(1, 1, 0, 0, 1);
      send55(20, 9);
      repeat (50) @(negedge clk);
      chk("R2 low level no completion", busy, 1);
      rx_in = 1'b1;
      repeat (2) @(negedge clk);
      chk("R2 busy two edges after rise", busy, 1);
      @(negedge clk);
      chk("R2 busy three edges after rise", busy, 0);
      repeat (20) @(negedge clk);

      // I: overflow saturates, then cleared by next start
      kick(1, 1, 1, 0, 1);
      send55(4100, 10);
      wait_idle();
      chk("R6 saturated divisor", divisor, MAXV);
      chk("R6 overflow flag", ovf_flag, 1);
      kick(1, 1, 0, 0, 1);
      @(negedge clk);
      chk("R6 overflow cleared on start", ovf_flag, 0);
      send55(20, 10);
      wait_idle();
      chk("R6 normal after overflow", divisor, 6);

      report();
   end
endmodule